// File: doc/BRIEF.md
# Register Rename Unit with Free List and Branch Checkpoints

This unit sits at the decode stage of an out-of-order core. It gives architectural register names physical names. A mapping table holds the current physical register for each logical register. A free list holds the physical registers that are not in use, and there are always more physical registers than logical ones.

For each instruction that the decoder offers, the unit translates both source names through the mapping table. If the instruction writes a register, the unit takes the oldest free physical register as the new destination and reports the mapping it replaces. The pipeline carries that replaced register with the instruction. When the instruction commits, the pipeline returns the replaced register through the commit port, and the unit appends it to the free list. When a branch is predicted, a snapshot of the table and the free-list read position can be stored in one of several checkpoint slots. A mispredict rolls both back to a chosen slot.

A two-state controller arbitrates the decode port. The states are ST_RUN, which accepts renames, and ST_RECOVER, a one-cycle bubble after a rollback. The transitions are:
- T_ROLLBACK: ST_RUN to ST_RECOVER when a restore is requested.
- T_RESUME: ST_RECOVER to ST_RUN when no further restore is requested.
- T_REROLL: ST_RECOVER to ST_RECOVER when another restore arrives.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i. The free list holds NUM_LOG up to NUM_PHYS-1 in ascending order, so the first destination handed out is NUM_LOG.
- R2: The source outputs give the mapping held before the same instruction's destination update, so a source equal to the destination reads the older physical register.
- R3: A granted instruction with a destination receives the free-list head on `ren_dst` in the same cycle. `ren_old` reports the mapping it replaces. From the next cycle the destination's logical register maps to `ren_dst`.
- R4: A request with a destination is not granted while the free list is empty. A request without a destination is still granted while the free list is empty.
- R5: A register returned on the commit port is appended to the tail of the free list, and registers are handed out in first-in first-out order.
- R6: A save stores into the selected slot the mapping table and free-list read position as they stand after that cycle's rename.
- R7: A restore reloads the mapping table and free-list read position from the selected slot. The decode port is not granted in the restore cycle or in the cycle after it.
- R8: When save and restore are requested in the same cycle, the restore is taken and the save is ignored.
- R9: No grant is given while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decoder offers an instruction |
| dec_src_a | input | $clog2(NUM_LOG) | First source logical register |
| dec_src_b | input | $clog2(NUM_LOG) | Second source logical register |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_dst | input | $clog2(NUM_LOG) | Destination logical register |
| dec_grant | output | 1 | Instruction renamed this cycle |
| ren_src_a | output | $clog2(NUM_PHYS) | Physical name of first source |
| ren_src_b | output | $clog2(NUM_PHYS) | Physical name of second source |
| ren_dst | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| ren_old | output | $clog2(NUM_PHYS) | Physical register previously mapped to the destination |
| cmt_valid | input | 1 | A committing instruction frees a register |
| cmt_free_reg | input | $clog2(NUM_PHYS) | Physical register to return to the free list |
| ck_save | input | 1 | Store a checkpoint |
| ck_save_slot | input | $clog2(NUM_CKPT) | Slot to store into |
| ck_restore | input | 1 | Roll back to a checkpoint |
| ck_restore_slot | input | $clog2(NUM_CKPT) | Slot to roll back to |

## Verification
The checks assume that the environment only returns registers that `ren_old` reported for instructions that are still alive, and returns each of them once. They also assume that a restore names a slot saved for a branch that is still in flight, and that nothing younger than that branch has committed. Under these rules the free list can never overflow, and registers re-exposed by a rollback cannot have been overwritten. The bench keeps a list of replaced registers for the instructions still alive and commits only from its oldest entry. It drops the entries younger than a checkpoint when it restores that checkpoint. While a checkpoint is live, it commits nothing younger than that checkpoint.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // Controller states of the rename port
    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_free_fifo.sv
// Circular free list of physical registers. The depth (NUM_PHYS-NUM_LOG) must be a power of two.
module rn_free_fifo #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pop,
    input  logic                           push,
    input  logic [$clog2(NUM_PHYS)-1:0]    push_reg,
    input  logic                           restore,
    input  logic [$clog2(NUM_PHYS-NUM_LOG):0] restore_head,
    output logic [$clog2(NUM_PHYS-NUM_LOG):0] head_nxt,
    output logic [$clog2(NUM_PHYS)-1:0]    top_reg,
    output logic                           empty
);
    localparam int DEPTH = NUM_PHYS - NUM_LOG;
    localparam int AW    = $clog2(DEPTH);
    localparam int HW    = AW + 1;
    localparam int PW    = $clog2(NUM_PHYS);

    logic [PW-1:0] slots [DEPTH];
    logic [HW-1:0] head_q, tail_q;
    logic [HW-1:0] count;

    assign count    = tail_q - head_q;
    assign empty    = (count == '0);
    assign top_reg  = slots[head_q[AW-1:0]];
    assign head_nxt = restore ? restore_head : head_q + HW'(pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= PW'(NUM_LOG + i);
            head_q <= '0;
            tail_q <= HW'(DEPTH);
        end else begin
            head_q <= head_nxt;
            if (push) begin
                slots[tail_q[AW-1:0]] <= push_reg;
                tail_q <= tail_q + 1'b1;
            end
        end
    end

    // R4: never allocate from an empty list
    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5: a returned register always finds room
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !restore) |-> (count < HW'(DEPTH)));
endmodule

// File: rtl/rn_map_table.sv
// Logical-to-physical mapping table with a bank of checkpoint slots.
module rn_map_table #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_CKPT = 2,
    parameter int HW       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_LOG)-1:0]    rd_a_idx,
    input  logic [$clog2(NUM_LOG)-1:0]    rd_b_idx,
    input  logic [$clog2(NUM_LOG)-1:0]    rd_old_idx,
    output logic [$clog2(NUM_PHYS)-1:0]   rd_a,
    output logic [$clog2(NUM_PHYS)-1:0]   rd_b,
    output logic [$clog2(NUM_PHYS)-1:0]   rd_old,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_LOG)-1:0]    wr_idx,
    input  logic [$clog2(NUM_PHYS)-1:0]   wr_val,
    input  logic                          save,
    input  logic [$clog2(NUM_CKPT)-1:0]   save_slot,
    input  logic [HW-1:0]                 save_head,
    input  logic                          restore,
    input  logic [$clog2(NUM_CKPT)-1:0]   restore_slot,
    output logic [HW-1:0]                 restore_head
);
    localparam int PW = $clog2(NUM_PHYS);
    localparam int FW = NUM_LOG * PW;

    logic [PW-1:0] map_q   [NUM_LOG];
    logic [PW-1:0] map_nxt [NUM_LOG];
    logic [FW-1:0] flat_nxt;
    logic [FW-1:0] ck_flat [NUM_CKPT];
    logic [HW-1:0] ck_head [NUM_CKPT];

    assign rd_a   = map_q[rd_a_idx];
    assign rd_b   = map_q[rd_b_idx];
    assign rd_old = map_q[rd_old_idx];
    assign restore_head = ck_head[restore_slot];

    always_comb begin
        for (int i = 0; i < NUM_LOG; i++) begin
            if (restore) map_nxt[i] = ck_flat[restore_slot][i*PW +: PW];
            else         map_nxt[i] = map_q[i];
        end
        if (!restore && wr_en) map_nxt[wr_idx] = wr_val;
        for (int i = 0; i < NUM_LOG; i++) flat_nxt[i*PW +: PW] = map_nxt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
        end else begin
            for (int i = 0; i < NUM_LOG; i++) map_q[i] <= map_nxt[i];
        end
    end

    // One snapshot bank per checkpoint slot
    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_ckpt
        logic [FW-1:0] snap_map;
        logic [HW-1:0] snap_head;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                snap_map  <= '0;
                snap_head <= '0;
            end else if (save && (save_slot == g)) begin
                snap_map  <= flat_nxt;
                snap_head <= save_head;
            end
        end
        assign ck_flat[g] = snap_map;
        assign ck_head[g] = snap_head;
    end

    // R3: a rename write lands in the table on the next cycle
    p_map_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore) |=> (map_q[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/rn_ctrl.sv
// Controller for the rename port: run / recover bubble after a rollback.
module rn_ctrl
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_has_dst,
    input  logic list_empty,
    input  logic ck_save,
    input  logic ck_restore,
    output logic grant,
    output logic alloc,
    output logic save_en,
    output logic restore_en
);
    rn_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (ck_restore) state_d = ST_RECOVER;   // T_ROLLBACK
            ST_RECOVER: state_d = ck_restore ? ST_RECOVER       // T_REROLL
                                             : ST_RUN;          // T_RESUME
            default:    state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        grant      = 1'b0;
        restore_en = ck_restore;
        save_en    = ck_save && !ck_restore;
        unique case (state_q)
            ST_RUN:     grant = dec_valid && !ck_restore && (!dec_has_dst || !list_empty);
            ST_RECOVER: grant = 1'b0;
            default:    grant = 1'b0;
        endcase
        alloc = grant && dec_has_dst;
    end
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_CKPT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dec_valid,
    input  logic [$clog2(NUM_LOG)-1:0]    dec_src_a,
    input  logic [$clog2(NUM_LOG)-1:0]    dec_src_b,
    input  logic                          dec_has_dst,
    input  logic [$clog2(NUM_LOG)-1:0]    dec_dst,
    output logic                          dec_grant,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_src_a,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_src_b,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_dst,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_old,
    input  logic                          cmt_valid,
    input  logic [$clog2(NUM_PHYS)-1:0]   cmt_free_reg,
    input  logic                          ck_save,
    input  logic [$clog2(NUM_CKPT)-1:0]   ck_save_slot,
    input  logic                          ck_restore,
    input  logic [$clog2(NUM_CKPT)-1:0]   ck_restore_slot
);
    localparam int HW = $clog2(NUM_PHYS - NUM_LOG) + 1;

    logic          list_empty, alloc, save_en, restore_en;
    logic [HW-1:0] head_nxt, restore_head;

    rn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .dec_has_dst(dec_has_dst),
        .list_empty (list_empty),
        .ck_save    (ck_save),
        .ck_restore (ck_restore),
        .grant      (dec_grant),
        .alloc      (alloc),
        .save_en    (save_en),
        .restore_en (restore_en)
    );

    rn_free_fifo #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (alloc),
        .push        (cmt_valid),
        .push_reg    (cmt_free_reg),
        .restore     (restore_en),
        .restore_head(restore_head),
        .head_nxt    (head_nxt),
        .top_reg     (ren_dst),
        .empty       (list_empty)
    );

    rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT), .HW(HW)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a_idx    (dec_src_a),
        .rd_b_idx    (dec_src_b),
        .rd_old_idx  (dec_dst),
        .rd_a        (ren_src_a),
        .rd_b        (ren_src_b),
        .rd_old      (ren_old),
        .wr_en       (alloc),
        .wr_idx      (dec_dst),
        .wr_val      (ren_dst),
        .save        (save_en),
        .save_slot   (ck_save_slot),
        .save_head   (head_nxt),
        .restore     (restore_en),
        .restore_slot(ck_restore_slot),
        .restore_head(restore_head)
    );

    // R9: no rename without a request
    p_no_idle_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_grant);
    // R7: the rollback cycle and the one after it are bubbles
    p_restore_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ck_restore |-> !dec_grant);
    p_recover_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ck_restore |=> !dec_grant);
endmodule

// File: tb/sim_reg_rename.sv
module sim_reg_rename;
    localparam int L = 8;
    localparam int P = 16;
    localparam int C = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_has_dst = 0, cmt_valid = 0, ck_save = 0, ck_restore = 0;
    logic [2:0] dec_src_a = 0, dec_src_b = 0, dec_dst = 0;
    logic [3:0] cmt_free_reg = 0;
    logic [0:0] ck_save_slot = 0, ck_restore_slot = 0;
    logic dec_grant;
    logic [3:0] ren_src_a, ren_src_b, ren_dst, ren_old;

    always #10 clk = ~clk;

    reg_rename #(.NUM_LOG(L), .NUM_PHYS(P), .NUM_CKPT(C)) u0 (.*);

    // Behavioural reference
    int map_m [L];
    int ckm [C][L];
    int ckh [C];
    int bound [C];
    bit live [C];
    int seq [$];
    int head_m;
    bit rec;
    int pend_old [$];
    int pend_idx [$];
    int nren;
    int errors = 0, checks = 0;
    string cur_tag = "R1";

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit v, int sa, int sb, bit hd, int d, bit cv, int cr,
                       bit sv, int ss, bit rs, int rsl);
        bit g, emp;
        dec_valid = v; dec_src_a = 3'(sa); dec_src_b = 3'(sb);
        dec_has_dst = hd; dec_dst = 3'(d);
        cmt_valid = cv; cmt_free_reg = 4'(cr);
        ck_save = sv; ck_save_slot = 1'(ss);
        ck_restore = rs; ck_restore_slot = 1'(rsl);
        #5;
        emp = (seq.size() - head_m) == 0;
        g = v && !rec && !rs && (!hd || !emp);
        check(cur_tag, int'(dec_grant), int'(g), "grant");
        if (g) begin
            check(cur_tag, int'(ren_src_a), map_m[sa], "src_a");
            check(cur_tag, int'(ren_src_b), map_m[sb], "src_b");
            if (hd) begin
                check(cur_tag, int'(ren_dst), seq[head_m], "dst");
                check(cur_tag, int'(ren_old), map_m[d], "old");
            end
        end
        if (rs) begin
            map_m = ckm[rsl];
            head_m = ckh[rsl];
            rec = 1;
            while (pend_idx.size() > 0 && pend_idx[$] >= bound[rsl]) begin
                void'(pend_idx.pop_back());
                void'(pend_old.pop_back());
            end
            nren = bound[rsl];
            live[rsl] = 0;
        end else begin
            rec = 0;
            if (g && hd) begin
                pend_old.push_back(map_m[d]);
                pend_idx.push_back(nren);
                nren++;
                map_m[d] = seq[head_m];
                head_m++;
            end
            if (sv) begin
                ckm[ss] = map_m;
                ckh[ss] = head_m;
                bound[ss] = nren;
                live[ss] = 1;
            end
        end
        if (cv) seq.push_back(cr);
        @(negedge clk);
    endtask

    // Rename one instruction with no side controls
    task automatic ren(bit hd, int d, int sa, int sb);
        cyc(1, sa, sb, hd, d, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic bit may_commit();
        if (pend_idx.size() == 0) return 0;
        for (int s = 0; s < C; s++)
            if (live[s] && pend_idx[0] >= bound[s]) return 0;
        return 1;
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < L; i++) map_m[i] = i;
        for (int i = L; i < P; i++) seq.push_back(i);
        head_m = 0; rec = 0; nren = 0;
        for (int s = 0; s < C; s++) begin live[s] = 0; bound[s] = 0; ckh[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset mapping is identity, first allocation is NUM_LOG
        cur_tag = "R1";
        for (int i = 0; i < L; i++) ren(0, 0, i, L - 1 - i);
        ren(1, 3, 3, 0);
        // R2: an instruction reading its own destination sees the older mapping
        cur_tag = "R2";
        ren(1, 3, 3, 3);
        ren(1, 4, 7, 3);
        // R3: a later redefinition replaces the mapping and reports the old one
        cur_tag = "R3";
        ren(1, 3, 2, 7);
        ren(0, 0, 3, 4);
        // R9: no grant while idle
        cur_tag = "R9";
        repeat (3) cyc(0, 1, 2, 1, 5, 0, 0, 0, 0, 0, 0);

        // R6 and R7: save, rename past it, roll back
        cur_tag = "R6";
        cyc(1, 1, 2, 1, 6, 0, 0, 1, 1, 0, 0);
        ren(1, 6, 6, 1);
        ren(1, 1, 6, 3);
        cur_tag = "R7";
        cyc(1, 6, 1, 1, 2, 0, 0, 0, 0, 1, 1);
        ren(1, 2, 6, 1);
        cur_tag = "R6";
        ren(0, 0, 6, 1);
        ren(1, 6, 6, 3);

        // R8: a save in the restore cycle is ignored
        cur_tag = "R8";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        ren(1, 1, 1, 2);
        cyc(1, 1, 2, 1, 0, 0, 0, 1, 0, 1, 0);
        ren(0, 0, 1, 0);
        ren(1, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        ren(0, 0, 0, 1);
        ren(0, 0, 2, 1);

        // R4: drain the free list, then stall
        cur_tag = "R4";
        for (int k = 0; k < 12; k++) ren(1, k % L, k % L, (k + 3) % L);
        ren(0, 0, 5, 6);
        // R5: a committed register is the next one handed out
        cur_tag = "R5";
        begin
            int r;
            r = pend_old.pop_front();
            void'(pend_idx.pop_front());
            cyc(0, 0, 0, 0, 0, 1, r, 0, 0, 0, 0);
        end
        ren(1, 2, 2, 4);
        ren(1, 3, 3, 4);

        // Mixed traffic
        for (int n = 0; n < 800; n++) begin
            bit v, hd, cv, sv, rs;
            int cr;
            cur_tag = (n % 2 == 0) ? "R3" : "R5";
            v  = ($urandom_range(3, 0) != 0);
            hd = ($urandom_range(3, 0) != 0);
            cv = may_commit() && ($urandom_range(1, 0) == 1);
            cr = 0;
            if (cv) begin
                cr = pend_old.pop_front();
                void'(pend_idx.pop_front());
            end
            rs = live[0] && ($urandom_range(15, 0) == 0);
            sv = !live[0] && !rs && ($urandom_range(7, 0) == 0);
            if (rs) cur_tag = "R7";
            cyc(v, $urandom_range(7, 0), $urandom_range(7, 0), hd, $urandom_range(7, 0),
                cv, cr, sv, 0, rs, 0);
        end
        summary();
    end
endmodule